// File: doc/BRIEF.md
# Debug Link Instruction Sequencer

This block sits behind the frame receiver of a two-wire program and debug link. It takes bytes that have already passed parity and stop-bit checks, plus break events, and follows the instruction stream. The first byte of each instruction is decoded into an opcode and a small argument field. The block then works out from packed size fields how many operand and data bytes follow. It groups those bytes into little-endian items and marks each item as written by the host or returned by the device. It signals when the instruction has finished.

A repeat instruction loads a counter. The next indirect load or indirect store then moves one extra data item for each count, and that instruction sets the counter back to zero. A break abandons whatever instruction is in progress, clears the counter, and makes the next accepted byte an opcode. The outputs are single-cycle strobes. A monitor or trace unit can consume them directly, with no handshake.

Top module: `dbg_insn_seq`

## Requirements
- R1: After reset, `op_vld_o`, `item_vld_o` and `insn_done_o` are low, and the first accepted byte is decoded as an opcode.
- R2: One cycle after an opcode byte, `op_vld_o` pulses for one cycle. `op_code_o` carries byte bits 7:5 and `op_arg_o` carries byte bits 4:0. `op_vld_o` and `item_vld_o` are never high in the same cycle.
- R3: Opcode 0 (direct load) gives two items. The first is an address of (bits 3:2)+1 bytes with direction 0. The second is data of (bits 1:0)+1 bytes with direction 1. Direction 1 means the device returned the item.
- R4: Opcode 2 (direct store) gives an address item of (bits 3:2)+1 bytes, then a data item of (bits 1:0)+1 bytes, both with direction 0.
- R5: Item bytes arrive least significant first. The first byte of an item lands in `item_data_o[7:0]`. Bytes above `item_len_o` read as zero.
- R6: Opcode 4 (control load) gives one 1-byte item with direction 1. Opcode 6 (control store) gives one 1-byte item with direction 0.
- R7: Opcode 7 (key) gives one 8-byte item with direction 0.
- R8: Opcode 5 (repeat) writes one count item of (bits 1:0)+1 bytes. The next opcode 1 (indirect load, direction 1) or opcode 3 (indirect store, direction 0) then transfers count+1 data items of (bits 1:0)+1 bytes, and the count returns to zero.
- R9: A pending repeat count is not changed by intervening direct, control or key instructions. Once it has been consumed, an indirect instruction transfers a single item.
- R10: A break pulses `insn_done_o` one cycle later. It abandons the current instruction without an item strobe and clears the repeat count. The next accepted byte is an opcode.
- R11: A byte that arrives in the same cycle as a break is dropped.
- R12: `item_vld_o` pulses one cycle after the last byte of an item. `insn_done_o` pulses in the same cycle as the last item of an instruction, and only then or after a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | A validated byte is present on `byte_i` |
| byte_i | input | 8 | Received byte |
| brk_i | input | 1 | Break event, one cycle |
| op_vld_o | output | 1 | Opcode strobe |
| op_code_o | output | 3 | Decoded opcode |
| op_arg_o | output | 5 | Low five bits of the opcode byte |
| item_vld_o | output | 1 | Item strobe |
| item_data_o | output | 64 | Assembled little-endian item value |
| item_len_o | output | 4 | Item size in bytes |
| item_dir_o | output | 1 | 0 = host wrote the item, 1 = device returned it |
| insn_done_o | output | 1 | Instruction complete, or aborted by a break |

## Verification
The assertions assume that `brk_i` and `byte_vld_i` are single-cycle pulses. They also assume that each strobe is sampled on the edge that follows it, so an opcode strobe and a completed item can never be reported from the same input cycle. The bench applies each byte and each break as a one-cycle pulse and then idles for one cycle. Every strobe is therefore isolated and can be compared at the next falling edge. Breaks are placed both in the middle of an instruction and together with a byte. This exercises the abort and drop paths without sending anything that is not a framed byte.

// File: rtl/dbg_insn_pkg.sv
package dbg_insn_pkg;
  typedef enum logic [2:0] {
    OP_LD_DIR  = 3'd0,
    OP_LD_IND  = 3'd1,
    OP_ST_DIR  = 3'd2,
    OP_ST_IND  = 3'd3,
    OP_LD_CSR  = 3'd4,
    OP_REPEAT  = 3'd5,
    OP_ST_CSR  = 3'd6,
    OP_KEY     = 3'd7
  } op_e;

  localparam logic DIR_HOST = 1'b0;
  localparam logic DIR_DEV  = 1'b1;
endpackage

// File: rtl/dbg_insn_dec.sv
module dbg_insn_dec
  import dbg_insn_pkg::*;
#(
  parameter int unsigned LEN_W     = 4,
  parameter int unsigned REP_W     = 32,
  parameter int unsigned KEY_BYTES = 8
) (
  input  logic [2:0]       op_bits_i,
  input  logic [3:0]       arg_i,
  input  logic [REP_W-1:0] rep_cnt_i,
  output op_e              op_o,
  output logic [LEN_W-1:0] first_len_o,
  output logic             first_dir_o,
  output logic [LEN_W-1:0] rest_len_o,
  output logic             rest_dir_o,
  output logic [REP_W-1:0] rest_cnt_o,
  output logic             take_rep_o
);
  logic [LEN_W-1:0] asz, dsz;

  always_comb begin
    op_o        = op_e'(op_bits_i);
    asz         = LEN_W'(arg_i[3:2]) + LEN_W'(1);
    dsz         = LEN_W'(arg_i[1:0]) + LEN_W'(1);
    first_len_o = dsz;
    first_dir_o = DIR_HOST;
    rest_len_o  = dsz;
    rest_dir_o  = DIR_HOST;
    rest_cnt_o  = '0;
    take_rep_o  = 1'b0;
    unique case (op_o)
      OP_LD_DIR: begin
        first_len_o = asz;
        rest_dir_o  = DIR_DEV;
        rest_cnt_o  = REP_W'(1);
      end
      OP_LD_IND: begin
        first_dir_o = DIR_DEV;
        rest_dir_o  = DIR_DEV;
        rest_cnt_o  = rep_cnt_i;
        take_rep_o  = 1'b1;
      end
      OP_ST_DIR: begin
        first_len_o = asz;
        rest_cnt_o  = REP_W'(1);
      end
      OP_ST_IND: begin
        rest_cnt_o  = rep_cnt_i;
        take_rep_o  = 1'b1;
      end
      OP_LD_CSR: begin
        first_len_o = LEN_W'(1);
        first_dir_o = DIR_DEV;
      end
      OP_ST_CSR: first_len_o = LEN_W'(1);
      OP_KEY:    first_len_o = LEN_W'(KEY_BYTES);
      default:   ;
    endcase
  end
endmodule

// File: rtl/dbg_item_asm.sv
module dbg_item_asm #(
  parameter int unsigned ITEM_BYTES = 8,
  parameter int unsigned LEN_W      = 4,
  localparam int unsigned ITEM_W    = ITEM_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [7:0]        byte_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              dir_i,
  input  logic              abort_i,
  output logic              last_o,
  output logic [ITEM_W-1:0] full_o,
  output logic              item_vld_o,
  output logic [ITEM_W-1:0] item_data_o,
  output logic [LEN_W-1:0]  item_len_o,
  output logic              item_dir_o
);
  logic [LEN_W-1:0]  idx_q;
  logic [ITEM_W-1:0] acc_q;

  assign full_o = acc_q | (ITEM_W'(byte_i) << {idx_q, 3'b000});
  assign last_o = push_i && (idx_q == len_i - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      acc_q       <= '0;
      item_vld_o  <= 1'b0;
      item_data_o <= '0;
      item_len_o  <= '0;
      item_dir_o  <= 1'b0;
    end else begin
      item_vld_o <= 1'b0;
      if (abort_i) begin
        idx_q <= '0;
        acc_q <= '0;
      end else if (push_i) begin
        if (last_o) begin
          item_vld_o  <= 1'b1;
          item_data_o <= full_o;
          item_len_o  <= len_i;
          item_dir_o  <= dir_i;
          idx_q       <= '0;
          acc_q       <= '0;
        end else begin
          acc_q <= full_o;
          idx_q <= idx_q + LEN_W'(1);
        end
      end
    end
  end

  p_upper_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_vld_o |-> ((item_data_o >> {item_len_o, 3'b000}) == '0));
  p_len_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_vld_o |-> (item_len_o != '0 && item_len_o <= LEN_W'(ITEM_BYTES)));
endmodule

// File: rtl/dbg_rep_cnt.sv
module dbg_rep_cnt #(
  parameter int unsigned REP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REP_W-1:0] val_i,
  input  logic             clr_i,
  output logic [REP_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (load_i) cnt_o <= val_i;
  end

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> (cnt_o == $past(val_i)));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/dbg_insn_seq.sv
module dbg_insn_seq
  import dbg_insn_pkg::*;
#(
  parameter int unsigned ITEM_BYTES = 8,
  parameter int unsigned REP_W      = 32,
  localparam int unsigned LEN_W     = $clog2(ITEM_BYTES + 1),
  localparam int unsigned ITEM_W    = ITEM_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              brk_i,
  output logic              op_vld_o,
  output logic [2:0]        op_code_o,
  output logic [4:0]        op_arg_o,
  output logic              item_vld_o,
  output logic [ITEM_W-1:0] item_data_o,
  output logic [LEN_W-1:0]  item_len_o,
  output logic              item_dir_o,
  output logic              insn_done_o
);
  logic             busy_q, is_rep_q;
  logic [LEN_W-1:0] cur_len_q, rest_len_q;
  logic             cur_dir_q, rest_dir_q;
  logic [REP_W-1:0] rest_cnt_q, rep_cnt;

  op_e              dec_op;
  logic [LEN_W-1:0] dec_first_len, dec_rest_len;
  logic             dec_first_dir, dec_rest_dir, dec_take;
  logic [REP_W-1:0] dec_rest_cnt;

  logic              asm_last;
  logic [ITEM_W-1:0] asm_full;

  logic accept, op_fire, dat_fire, insn_end;
  assign accept   = byte_vld_i && !brk_i;   // break drops a coincident byte
  assign op_fire  = accept && !busy_q;
  assign dat_fire = accept && busy_q;
  assign insn_end = dat_fire && asm_last && (rest_cnt_q == '0);

  dbg_insn_dec #(.LEN_W(LEN_W), .REP_W(REP_W), .KEY_BYTES(ITEM_BYTES)) u_dec (
    .op_bits_i   (byte_i[7:5]),
    .arg_i       (byte_i[3:0]),
    .rep_cnt_i   (rep_cnt),
    .op_o        (dec_op),
    .first_len_o (dec_first_len),
    .first_dir_o (dec_first_dir),
    .rest_len_o  (dec_rest_len),
    .rest_dir_o  (dec_rest_dir),
    .rest_cnt_o  (dec_rest_cnt),
    .take_rep_o  (dec_take)
  );

  dbg_item_asm #(.ITEM_BYTES(ITEM_BYTES), .LEN_W(LEN_W)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (dat_fire),
    .byte_i      (byte_i),
    .len_i       (cur_len_q),
    .dir_i       (cur_dir_q),
    .abort_i     (brk_i),
    .last_o      (asm_last),
    .full_o      (asm_full),
    .item_vld_o  (item_vld_o),
    .item_data_o (item_data_o),
    .item_len_o  (item_len_o),
    .item_dir_o  (item_dir_o)
  );

  dbg_rep_cnt #(.REP_W(REP_W)) u_rep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (insn_end && is_rep_q),
    .val_i  (asm_full[REP_W-1:0]),
    .clr_i  (brk_i || (op_fire && dec_take)),
    .cnt_o  (rep_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      is_rep_q    <= 1'b0;
      cur_len_q   <= '0;
      cur_dir_q   <= 1'b0;
      rest_len_q  <= '0;
      rest_dir_q  <= 1'b0;
      rest_cnt_q  <= '0;
      op_vld_o    <= 1'b0;
      op_code_o   <= '0;
      op_arg_o    <= '0;
      insn_done_o <= 1'b0;
    end else begin
      op_vld_o    <= op_fire;
      insn_done_o <= brk_i || insn_end;
      if (op_fire) begin
        op_code_o <= dec_op;
        op_arg_o  <= byte_i[4:0];
      end
      if (brk_i) begin
        busy_q <= 1'b0;
      end else if (op_fire) begin
        busy_q     <= 1'b1;
        is_rep_q   <= (dec_op == OP_REPEAT);
        cur_len_q  <= dec_first_len;
        cur_dir_q  <= dec_first_dir;
        rest_len_q <= dec_rest_len;
        rest_dir_q <= dec_rest_dir;
        rest_cnt_q <= dec_rest_cnt;
      end else if (dat_fire && asm_last) begin
        if (rest_cnt_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          cur_len_q  <= rest_len_q;
          cur_dir_q  <= rest_dir_q;
          rest_cnt_q <= rest_cnt_q - REP_W'(1);
        end
      end
    end
  end

  p_brk_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> insn_done_o);
  p_brk_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> (!op_vld_o && !item_vld_o));
  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_vld_o && item_vld_o));
  p_done_cause_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_done_o |-> (item_vld_o || $past(brk_i)));
  p_op_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !brk_i && !busy_q) |=> (op_vld_o && busy_q));
endmodule

// File: tb/dbg_insn_seq_test.sv
module dbg_insn_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        brk_i = 1'b0;
  logic        op_vld_o;
  logic [2:0]  op_code_o;
  logic [4:0]  op_arg_o;
  logic        item_vld_o;
  logic [63:0] item_data_o;
  logic [3:0]  item_len_o;
  logic        item_dir_o;
  logic        insn_done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  dbg_insn_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .brk_i(brk_i), .op_vld_o(op_vld_o), .op_code_o(op_code_o), .op_arg_o(op_arg_o),
    .item_vld_o(item_vld_o), .item_data_o(item_data_o), .item_len_o(item_len_o),
    .item_dir_o(item_dir_o), .insn_done_o(insn_done_o)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // drive one byte (optionally with a break), outputs valid at next negedge
  task automatic pulse(input logic vld, input logic [7:0] b, input logic brk);
    @(negedge clk_i);
    byte_vld_i = vld; byte_i = b; brk_i = brk;
    @(negedge clk_i);
    byte_vld_i = 1'b0; brk_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    pulse(1'b1, b, 1'b0);
  endtask

  task automatic expect_quiet(input string req);
    check(req, "op_vld", op_vld_o, 0);
    check(req, "item_vld", item_vld_o, 0);
    check(req, "done", insn_done_o, 0);
  endtask

  task automatic expect_op(input string req, input logic [2:0] code, input logic [4:0] arg);
    check(req, "op_vld", op_vld_o, 1);
    check(req, "op_code", op_code_o, code);
    check(req, "op_arg", op_arg_o, arg);
    check(req, "item_vld", item_vld_o, 0);
    check(req, "done", insn_done_o, 0);
  endtask

  task automatic expect_item(input string req, input logic [63:0] data,
                             input logic [3:0] len, input logic dir, input logic done);
    check(req, "item_vld", item_vld_o, 1);
    check(req, "item_data", item_data_o, data);
    check(req, "item_len", item_len_o, len);
    check(req, "item_dir", item_dir_o, dir);
    check(req, "done", insn_done_o, done);
    check(req, "op_vld", op_vld_o, 0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    expect_quiet("R1");
  endtask

  task automatic t_direct_load;  // R3, R5, R12
    send(8'h05); expect_op("R1", 3'd0, 5'h05);
    send(8'h34); expect_quiet("R5");
    send(8'h12); expect_item("R3", 64'h1234, 4'd2, 1'b0, 1'b0);
    send(8'hCD); expect_quiet("R12");
    send(8'hAB); expect_item("R3", 64'hABCD, 4'd2, 1'b1, 1'b1);
  endtask

  task automatic t_direct_store;  // R4
    send(8'h4C); expect_op("R2", 3'd2, 5'h0C);
    send(8'h01); send(8'h02); send(8'h03); expect_quiet("R4");
    send(8'h04); expect_item("R4", 64'h04030201, 4'd4, 1'b0, 1'b0);
    send(8'h99); expect_item("R4", 64'h99, 4'd1, 1'b0, 1'b1);
  endtask

  task automatic t_control;  // R6
    send(8'h82); expect_op("R6", 3'd4, 5'h02);
    send(8'h5A); expect_item("R6", 64'h5A, 4'd1, 1'b1, 1'b1);
    send(8'hDF); expect_op("R6", 3'd6, 5'h1F);
    send(8'h77); expect_item("R6", 64'h77, 4'd1, 1'b0, 1'b1);
  endtask

  task automatic t_key;  // R7
    send(8'hE0); expect_op("R7", 3'd7, 5'h00);
    for (int i = 1; i < 8; i++) begin
      send(8'(i * 17)); expect_quiet("R7");
    end
    send(8'h88); expect_item("R7", 64'h8877665544332211, 4'd8, 1'b0, 1'b1);
  endtask

  task automatic t_repeat_load;  // R8, R9
    send(8'hA0); expect_op("R8", 3'd5, 5'h00);
    send(8'h02); expect_item("R8", 64'h02, 4'd1, 1'b0, 1'b1);
    send(8'hC3); expect_op("R9", 3'd6, 5'h03);
    send(8'h00); expect_item("R9", 64'h00, 4'd1, 1'b0, 1'b1);
    send(8'h20); expect_op("R8", 3'd1, 5'h00);
    send(8'h10); expect_item("R8", 64'h10, 4'd1, 1'b1, 1'b0);
    send(8'h11); expect_item("R8", 64'h11, 4'd1, 1'b1, 1'b0);
    send(8'h12); expect_item("R8", 64'h12, 4'd1, 1'b1, 1'b1);
    send(8'h20); expect_op("R9", 3'd1, 5'h00);
    send(8'h13); expect_item("R9", 64'h13, 4'd1, 1'b1, 1'b1);
  endtask

  task automatic t_repeat_store;  // R8 with two-byte count and items
    send(8'hA1); expect_op("R8", 3'd5, 5'h01);
    send(8'h01); expect_quiet("R8");
    send(8'h00); expect_item("R8", 64'h0001, 4'd2, 1'b0, 1'b1);
    send(8'h61); expect_op("R8", 3'd3, 5'h01);
    send(8'hEF); send(8'hBE); expect_item("R8", 64'hBEEF, 4'd2, 1'b0, 1'b0);
    send(8'hAD); send(8'hDE); expect_item("R8", 64'hDEAD, 4'd2, 1'b0, 1'b1);
  endtask

  task automatic t_break;  // R10
    send(8'h05); expect_op("R10", 3'd0, 5'h05);
    send(8'h11); expect_quiet("R10");
    pulse(1'b0, 8'h00, 1'b1);
    check("R10", "done", insn_done_o, 1);
    check("R10", "item_vld", item_vld_o, 0);
    send(8'hC2); expect_op("R10", 3'd6, 5'h02);
    send(8'h44); expect_item("R10", 64'h44, 4'd1, 1'b0, 1'b1);
    send(8'hA0); send(8'h03); expect_item("R10", 64'h03, 4'd1, 1'b0, 1'b1);
    pulse(1'b0, 8'h00, 1'b1);
    check("R10", "done", insn_done_o, 1);
    send(8'h20); expect_op("R10", 3'd1, 5'h00);
    send(8'h55); expect_item("R10", 64'h55, 4'd1, 1'b1, 1'b1);
  endtask

  task automatic t_break_with_byte;  // R11
    send(8'h4C); expect_op("R11", 3'd2, 5'h0C);
    pulse(1'b1, 8'h82, 1'b1);
    check("R11", "done", insn_done_o, 1);
    check("R11", "op_vld", op_vld_o, 0);
    check("R11", "item_vld", item_vld_o, 0);
    send(8'h82); expect_op("R11", 3'd4, 5'h02);
    send(8'h66); expect_item("R11", 64'h66, 4'd1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_direct_load();
    t_direct_store();
    t_control();
    t_key();
    t_repeat_load();
    t_repeat_store();
    t_break();
    t_break_with_byte();
    repeat (2) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule